// File: doc/BRIEF.md
# Byte-Serial Up/Down Counter Channel

This block is a single 24-bit up/down counter with an 8-bit bus front end. The bus has two ports, chosen by `bus_ctl`: a data port that moves bytes in and out of a preset register and an output latch, and a control port that takes command and mode bytes and returns a flag byte. Multi-byte values always travel least significant byte first. Each value advances an internal byte pointer, and a command can return that pointer to byte 0.

The counter steps once per clock on which `cnt_pulse` is high and counting is enabled. `cnt_up` gives the direction. The counter cannot be written directly. Software writes the preset and then commands a load, or an index event loads the preset when that option is selected. Reads never see the live count. Software first takes a snapshot into the output latch and then reads the latch byte by byte. Four count modes choose what happens at the ends of the range. Borrow and carry record underflow and overflow. A sticky error flag records the noise input.

Top module: `byte_counter_channel`

## Requirements
- R1: After reset the flag byte reads 0x00, the latch and preset are zero, the count mode is normal, and counting is disabled.
- R2: Data-port writes fill the preset through the write pointer, byte 0 (bits 7:0) first. Control byte 0x08 copies the preset into the counter.
- R3: Control byte 0x11 copies the live counter into the output latch and resets the byte pointers. Data-port reads return latch bytes least significant first. The latch keeps its value until the next snapshot.
- R4: Control byte 0x01 resets both byte pointers to byte 0. Each pointer advances on its own access type and wraps from byte 2 to byte 0.
- R5: Control byte 0x40|c sets I/O control. When c bit 0 is 0, count pulses have no effect on the counter.
- R6: Control byte 0x20|(m<<1) selects count mode m. In normal mode (m=0) the counter wraps: stepping down from 0 gives 0xFFFFFF and sets borrow (flag bit 0), and stepping up from 0xFFFFFF gives 0 and sets carry (flag bit 1). Flag bit 5 holds the direction of the last qualified pulse, with 1 meaning up.
- R7: In range-limit mode (m=1) the count holds at the preset when stepping up, setting carry, and holds at 0 when stepping down, setting borrow.
- R8: In non-recycle mode (m=2) the counter wraps as in normal mode and then ignores pulses until it is loaded from the preset.
- R9: In modulo-N mode (m=3), stepping up from the preset gives 0 and sets carry, and stepping down from 0 gives the preset and sets borrow.
- R10: When I/O control bit 1 is 0, an `index_evt` cycle loads the counter from the preset. When bit 1 is 1, index events are ignored.
- R11: `noise_err` sets the sticky error flag (bit 4). Control bytes 0x02 and 0x04 clear borrow and carry but not error. Control byte 0x06 clears error only.
- R12: `bus_rdata` is registered. It takes the addressed value on the clock edge that samples `bus_rd` and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_rd | input | 1 | Read strobe, one byte per cycle |
| bus_ctl | input | 1 | 1 selects the control port, 0 selects the data port |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Registered read byte |
| cnt_pulse | input | 1 | Count request for this clock |
| cnt_up | input | 1 | Count direction, 1 = up |
| index_evt | input | 1 | Index event, one cycle |
| noise_err | input | 1 | Noise detected on the count inputs |

## Verification
Every register write, load, snapshot, flag update and count step becomes visible at the first clock edge after the cycle that presents it. A read strobe has its byte in `bus_rdata` just after that same edge. The bench drives inputs on falling edges. It samples `bus_rdata` on the falling edge after each strobe, so every expected value is due exactly one edge after its stimulus. A behavioural model updates on each rising edge and predicts `bus_rdata` every cycle. Directed reads compare snapshots and flag bytes with constants worked out from the requirements.

// File: rtl/qc_pkg.sv
package qc_pkg;
  typedef enum logic [1:0] {
    MODE_WRAP      = 2'd0,
    MODE_CLAMP     = 2'd1,
    MODE_ONESHOT   = 2'd2,
    MODE_MODULO    = 2'd3
  } cmode_e;

  typedef struct packed {
    logic ptr_rst;
    logic snap;
    logic load;
    logic clr_bc;
    logic clr_err;
    logic mode_wr;
    logic io_wr;
    logic data_wr;
    logic data_rd;
  } cmd_t;

  localparam logic [2:0] GRP_CMD  = 3'b000;
  localparam logic [2:0] GRP_MODE = 3'b001;
  localparam logic [2:0] GRP_IO   = 3'b010;
endpackage

// File: rtl/qc_cmd_decode.sv
module qc_cmd_decode
  import qc_pkg::*;
(
  input  logic       wr,
  input  logic       rd,
  input  logic       ctl,
  input  logic [7:0] wdata,
  output cmd_t       cmd
);
  logic       ctl_wr;
  logic [2:0] grp;

  always_comb begin
    ctl_wr      = wr && ctl;
    grp         = wdata[7:5];
    cmd         = '0;
    cmd.data_wr = wr && !ctl;
    cmd.data_rd = rd && !ctl;
    if (ctl_wr && grp == GRP_CMD) begin
      cmd.ptr_rst = wdata[0];
      cmd.snap    = wdata[4];
      cmd.load    = wdata[3];
      cmd.clr_bc  = (wdata[2:1] == 2'b01) || (wdata[2:1] == 2'b10);
      cmd.clr_err = (wdata[2:1] == 2'b11);
    end
    cmd.mode_wr = ctl_wr && (grp == GRP_MODE);
    cmd.io_wr   = ctl_wr && (grp == GRP_IO);
  end
endmodule

// File: rtl/qc_byte_regs.sv
module qc_byte_regs #(
  parameter int CNT_W  = 24,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ptr_rst,
  input  logic              snap,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [CNT_W-1:0]  count_val,
  output logic [CNT_W-1:0]  preset_val,
  output logic [CNT_W-1:0]  latch_val,
  output logic [BYTE_W-1:0] latch_byte
);
  localparam int NB = CNT_W / BYTE_W;
  localparam int PW = (NB > 1) ? $clog2(NB) : 1;
  localparam logic [PW-1:0] LAST = PW'(NB - 1);

  logic [PW-1:0] wp, rp;
  logic [NB-1:0][BYTE_W-1:0] preset_b;
  logic [NB-1:0][BYTE_W-1:0] latch_b;

  always_ff @(posedge clk) begin
    if (rst || ptr_rst) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (data_wr) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (data_rd) rp <= (rp == LAST) ? '0 : rp + 1'b1;
    end
  end

  for (genvar i = 0; i < NB; i++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst) begin
        preset_b[i] <= '0;
        latch_b[i]  <= '0;
      end else begin
        if (data_wr && wp == PW'(i)) preset_b[i] <= wdata;
        if (snap) latch_b[i] <= count_val[i*BYTE_W +: BYTE_W];
      end
    end
  end

  assign preset_val = preset_b;
  assign latch_val  = latch_b;
  assign latch_byte = latch_b[rp];
endmodule

// File: rtl/qc_count_core.sv
module qc_count_core
  import qc_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             up,
  input  logic             load,
  input  logic [CNT_W-1:0] preset_val,
  input  logic             mode_wr,
  input  logic [1:0]       mode_sel,
  input  logic             clr_bc,
  input  logic             clr_err,
  input  logic             noise,
  output logic [CNT_W-1:0] count_val,
  output logic             borrow,
  output logic             carry,
  output logic             err,
  output logic             dir
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  cmode_e           mode;
  logic             halted;
  logic [CNT_W-1:0] nxt;
  logic             hit_c, hit_b, stop;

  always_comb begin
    nxt   = count_val;
    hit_c = 1'b0;
    hit_b = 1'b0;
    stop  = 1'b0;
    if (load) begin
      nxt = preset_val;
    end else if (step && !halted) begin
      unique case (mode)
        MODE_WRAP, MODE_ONESHOT: begin
          if (up) begin
            hit_c = (count_val == TOP);
            nxt   = count_val + 1'b1;
          end else begin
            hit_b = (count_val == '0);
            nxt   = count_val - 1'b1;
          end
          stop = (mode == MODE_ONESHOT) && (hit_c || hit_b);
        end
        MODE_CLAMP: begin
          if (up) begin
            hit_c = (count_val == preset_val);
            if (!hit_c) nxt = count_val + 1'b1;
          end else begin
            hit_b = (count_val == '0);
            if (!hit_b) nxt = count_val - 1'b1;
          end
        end
        MODE_MODULO: begin
          if (up) begin
            hit_c = (count_val == preset_val);
            nxt   = hit_c ? '0 : count_val + 1'b1;
          end else begin
            hit_b = (count_val == '0);
            nxt   = hit_b ? preset_val : count_val - 1'b1;
          end
        end
        default: nxt = count_val;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_val <= '0;
      mode      <= MODE_WRAP;
      halted    <= 1'b0;
      borrow    <= 1'b0;
      carry     <= 1'b0;
      err       <= 1'b0;
      dir       <= 1'b0;
    end else begin
      count_val <= nxt;
      if (mode_wr) mode <= cmode_e'(mode_sel);
      if (load) halted <= 1'b0;
      else if (stop) halted <= 1'b1;
      if (step && !load) dir <= up;
      borrow <= (borrow && !clr_bc) || hit_b;
      carry  <= (carry && !clr_bc) || hit_c;
      err    <= (err && !clr_err) || noise;
    end
  end
endmodule

// File: rtl/byte_counter_channel.sv
module byte_counter_channel
  import qc_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_ctl,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              cnt_pulse,
  input  logic              cnt_up,
  input  logic              index_evt,
  input  logic              noise_err
);
  cmd_t              cmd;
  logic              cnt_en;
  logic              idx_off;
  logic [CNT_W-1:0]  count_val, preset_val, latch_val;
  logic [BYTE_W-1:0] latch_byte;
  logic              flag_borrow, flag_carry, flag_err, flag_dir;
  logic [BYTE_W-1:0] flag_byte;

  qc_cmd_decode u_dec (
    .wr(bus_wr), .rd(bus_rd), .ctl(bus_ctl), .wdata(bus_wdata[7:0]), .cmd(cmd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_en  <= 1'b0;
      idx_off <= 1'b0;
    end else if (cmd.io_wr) begin
      cnt_en  <= bus_wdata[0];
      idx_off <= bus_wdata[1];
    end
  end

  qc_byte_regs #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_regs (
    .clk(clk), .rst(rst), .ptr_rst(cmd.ptr_rst), .snap(cmd.snap),
    .data_wr(cmd.data_wr), .data_rd(cmd.data_rd), .wdata(bus_wdata),
    .count_val(count_val), .preset_val(preset_val), .latch_val(latch_val),
    .latch_byte(latch_byte)
  );

  qc_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst),
    .step(cnt_pulse && cnt_en), .up(cnt_up),
    .load(cmd.load || (index_evt && !idx_off)),
    .preset_val(preset_val),
    .mode_wr(cmd.mode_wr), .mode_sel(bus_wdata[2:1]),
    .clr_bc(cmd.clr_bc), .clr_err(cmd.clr_err), .noise(noise_err),
    .count_val(count_val), .borrow(flag_borrow), .carry(flag_carry),
    .err(flag_err), .dir(flag_dir)
  );

  always_comb begin
    flag_byte    = '0;
    flag_byte[0] = flag_borrow;
    flag_byte[1] = flag_carry;
    flag_byte[4] = flag_err;
    flag_byte[5] = flag_dir;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= bus_ctl ? flag_byte : latch_byte;
  end
endmodule

// File: rtl/qc_channel_checker.sv
module qc_channel_checker #(
  parameter int CNT_W  = 24,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_ctl,
  input logic [BYTE_W-1:0] bus_wdata,
  input logic              cnt_pulse,
  input logic              index_evt,
  input logic              noise_err,
  input logic              cnt_en,
  input logic [CNT_W-1:0]  count_val,
  input logic [CNT_W-1:0]  latch_val,
  input logic [CNT_W-1:0]  preset_val,
  input logic              flag_err
);
  logic is_cmd, is_load, is_snap;
  assign is_cmd  = bus_wr && bus_ctl && bus_wdata[7:5] == 3'b000;
  assign is_load = is_cmd && bus_wdata[3];
  assign is_snap = is_cmd && bus_wdata[4];

  assert_load_from_preset_R2: assert property (@(posedge clk) disable iff (rst)
    is_load |=> count_val == $past(preset_val));

  assert_latch_holds_R3: assert property (@(posedge clk) disable iff (rst)
    !is_snap |=> $stable(latch_val));

  assert_snap_copies_R3: assert property (@(posedge clk) disable iff (rst)
    is_snap |=> latch_val == $past(count_val));

  assert_idle_count_R5: assert property (@(posedge clk) disable iff (rst)
    (!(cnt_pulse && cnt_en) && !is_load && !index_evt) |=> $stable(count_val));

  assert_err_set_R11: assert property (@(posedge clk) disable iff (rst)
    noise_err |=> flag_err);

  assert_err_clear_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_ctl && bus_wdata == 8'h06 && !noise_err) |=> !flag_err);
endmodule

bind byte_counter_channel qc_channel_checker #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/tb_byte_counter_channel.sv
module tb_byte_counter_channel;
  logic clk = 0, rst = 1;
  logic bus_wr = 0, bus_rd = 0, bus_ctl = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic cnt_pulse = 0, cnt_up = 0, index_evt = 0, noise_err = 0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string cur = "R12";

  always #5 clk = ~clk;

  byte_counter_channel dut (.*);

  // behavioural reference
  logic [23:0] m_cnt, m_pre, m_lat;
  int m_wp, m_rp, m_mode;
  bit m_en, m_noidx, m_halt, m_b, m_c, m_e, m_dir;
  logic [7:0] m_rd;

  function automatic logic [7:0] m_flags();
    return {2'b00, m_dir, m_e, 2'b00, m_c, m_b};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_pre = 0; m_lat = 0; m_wp = 0; m_rp = 0; m_mode = 0;
      m_en = 0; m_noidx = 0; m_halt = 0; m_b = 0; m_c = 0; m_e = 0; m_dir = 0; m_rd = 0;
    end else begin
      bit ld, hb, hc;
      ld = 0; hb = 0; hc = 0;
      if (bus_rd) begin
        if (bus_ctl) m_rd = m_flags();
        else begin m_rd = m_lat[8*m_rp +: 8]; m_rp = (m_rp + 1) % 3; end
      end
      if (bus_wr && !bus_ctl) begin
        m_pre[8*m_wp +: 8] = bus_wdata; m_wp = (m_wp + 1) % 3;
      end
      if (bus_wr && bus_ctl) begin
        case (bus_wdata[7:5])
          3'd0: begin
            if (bus_wdata[4]) m_lat = m_cnt;
            if (bus_wdata[0]) begin m_wp = 0; m_rp = 0; end
            if (bus_wdata[3]) ld = 1;
            if (bus_wdata[2:1] == 1 || bus_wdata[2:1] == 2) begin m_b = 0; m_c = 0; end
            if (bus_wdata[2:1] == 3) m_e = 0;
          end
          3'd1: m_mode = bus_wdata[2:1];
          3'd2: begin m_en = bus_wdata[0]; m_noidx = bus_wdata[1]; end
          default: ;
        endcase
      end
      if (index_evt && !dut_noidx_prev) ld = 1;
      if (ld) begin m_cnt = dut_pre_prev; m_halt = 0; end
      else if (cnt_pulse && dut_en_prev) begin
        m_dir = cnt_up;
        if (!m_halt) begin
          if (cnt_up) begin
            if ((m_mode == 1 || m_mode == 3) && m_cnt == dut_pre_prev) begin
              hc = 1; if (m_mode == 3) m_cnt = 0;
            end else begin
              if (m_cnt == 24'hFFFFFF) hc = 1;
              m_cnt = m_cnt + 1;
            end
          end else begin
            if (m_cnt == 0) begin
              hb = 1;
              if (m_mode == 3) m_cnt = dut_pre_prev;
              else if (m_mode != 1) m_cnt = 24'hFFFFFF;
            end else m_cnt = m_cnt - 1;
          end
          if (m_mode == 2 && (hb || hc)) m_halt = 1;
        end
      end
      if (hb) m_b = 1;
      if (hc) m_c = 1;
      if (noise_err) m_e = 1;
    end
  end

  // settings as they stood before this edge (register semantics)
  logic [23:0] dut_pre_prev;
  bit dut_en_prev, dut_noidx_prev;
  always @(negedge clk) begin
    dut_pre_prev   = m_pre;
    dut_en_prev    = m_en;
    dut_noidx_prev = m_noidx;
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (!rst && !done) chk({cur, " rdata vs model, R12"}, bus_rdata, m_rd);

  task automatic wr(bit ctl, logic [7:0] d);
    @(negedge clk); bus_ctl = ctl; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(bit ctl, output logic [7:0] d);
    @(negedge clk); bus_ctl = ctl; bus_rd = 1;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic rd3(output logic [23:0] v);
    logic [7:0] b;
    for (int i = 0; i < 3; i++) begin rd(0, b); v[8*i +: 8] = b; end
  endtask

  task automatic snap(output logic [23:0] v);
    wr(1, 8'h11); rd3(v);
  endtask

  task automatic preset(logic [23:0] v);
    wr(1, 8'h01);
    for (int i = 0; i < 3; i++) wr(0, v[8*i +: 8]);
  endtask

  task automatic pulses(int n, bit up);
    @(negedge clk); cnt_up = up; cnt_pulse = 1;
    repeat (n) @(negedge clk);
    cnt_pulse = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [23:0] v;
    logic [7:0] f;
    repeat (3) @(negedge clk);
    rst = 0;

    cur = "R1";
    rd(1, f); chk("R1 reset flags", f, 8'h00);
    pulses(3, 1);
    snap(v); chk("R1 R5 disabled count stays 0", v, 0);

    cur = "R2";
    preset(24'h123456); wr(1, 8'h08);
    snap(v); chk("R2 R3 preset load then snapshot", v, 24'h123456);

    cur = "R4";
    wr(1, 8'h01);
    wr(0, 8'hAA); wr(0, 8'hBB); wr(0, 8'hCC); wr(0, 8'hDD);
    wr(1, 8'h08);
    snap(v); chk("R4 write pointer wraps", v, 24'hCCBBDD);
    wr(1, 8'h11); rd(0, f); chk("R3 first byte is LSB", f, 8'hDD);
    wr(1, 8'h01); rd3(v); chk("R4 pointer reset rereads from byte 0", v, 24'hCCBBDD);
    cur = "R3";
    preset(24'h000001); wr(1, 8'h08);
    wr(1, 8'h01); rd3(v); chk("R3 latch holds without snapshot", v, 24'hCCBBDD);

    cur = "R6";
    wr(1, 8'h41); wr(1, 8'h20);
    preset(0); wr(1, 8'h08);
    pulses(1, 0);
    snap(v); chk("R6 underflow wraps", v, 24'hFFFFFF);
    rd(1, f); chk("R6 borrow set, dir down", f, 8'h01);
    wr(1, 8'h02); rd(1, f); chk("R11 0x02 clears borrow", f, 8'h00);
    pulses(1, 1);
    snap(v); chk("R6 overflow wraps", v, 0);
    rd(1, f); chk("R6 carry set, dir up", f, 8'h22);
    wr(1, 8'h04); rd(1, f); chk("R11 0x04 clears carry", f, 8'h20);
    pulses(2, 1);
    snap(v); chk("R6 normal counts up", v, 2);

    cur = "R5";
    wr(1, 8'h40); pulses(4, 1);
    snap(v); chk("R5 disabled ignores pulses", v, 2);
    wr(1, 8'h41);

    cur = "R7";
    wr(1, 8'h22); preset(5); wr(1, 8'h08);
    pulses(2, 1);
    snap(v); chk("R7 holds at preset", v, 5);
    pulses(7, 0);
    snap(v); chk("R7 holds at zero", v, 0);
    rd(1, f); chk("R7 borrow and carry", f, 8'h03);

    cur = "R8";
    wr(1, 8'h02); wr(1, 8'h24); preset(24'hFFFFFE); wr(1, 8'h08);
    pulses(3, 1);
    snap(v); chk("R8 stops after wrap", v, 0);
    rd(1, f); chk("R8 carry on wrap", f, 8'h22);
    wr(1, 8'h08); pulses(1, 1);
    snap(v); chk("R8 resumes after load", v, 24'hFFFFFF);

    cur = "R9";
    wr(1, 8'h04); wr(1, 8'h26); preset(3); wr(1, 8'h08);
    pulses(1, 1);
    snap(v); chk("R9 up past preset clears", v, 0);
    pulses(2, 1);
    snap(v); chk("R9 counts up", v, 2);
    pulses(3, 0);
    snap(v); chk("R9 down past zero reloads", v, 3);
    rd(1, f); chk("R9 borrow and carry", f, 8'h03);

    cur = "R10";
    wr(1, 8'h20); preset(24'h000010);
    @(negedge clk); index_evt = 1; @(negedge clk); index_evt = 0;
    snap(v); chk("R10 index loads preset", v, 24'h10);
    wr(1, 8'h43); pulses(1, 1);
    @(negedge clk); index_evt = 1; @(negedge clk); index_evt = 0;
    snap(v); chk("R10 index ignored when bit1 set", v, 24'h11);

    cur = "R11";
    @(negedge clk); noise_err = 1; @(negedge clk); noise_err = 0;
    rd(1, f); chk("R11 noise sets error", f & 8'h10, 8'h10);
    wr(1, 8'h02); rd(1, f); chk("R11 0x02 keeps error", f & 8'h10, 8'h10);
    wr(1, 8'h06); rd(1, f); chk("R11 0x06 clears error", f & 8'h10, 8'h00);

    cur = "R12";
    repeat (3) @(negedge clk);
    chk("R12 rdata holds between reads", bus_rdata, f);
    finish_run();
  end
endmodule